// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block holds the control and status word of a real-time clock. It lives in the bus clock domain and feeds a slower RTC clock domain. The fields that steer the running clock are the run enable and the two alarm interrupt enables. They are held in the bus domain, copied into the RTC domain through a toggle handshake, and guarded by a busy flag. The run enable is also gated by a key bit. The same word carries a ready flag, two alarm flags, a ready interrupt enable and a square-wave output selector. Software reads the whole word at any time on a combinational read port.

Stub pulses take the place of the calendar counter and the alarm comparators. `cnt_pre_i` fires just before a count update and `cnt_upd_i` fires when the count registers change. `tod_hit_i` and `ssec_hit_i` mark alarm matches. The block derives an interrupt line and a wake line from the flags. It also produces a square wave in the RTC domain from one of four sources.

Top module: `rtc_ctl_reg`

## Requirements
- R1: Out of reset the read word is 0x00000008: busy (bit 3) is 1 and every other bit is 0. `irq_o`, `wake_o` and `sqw_o` are 0.
- R2: A write to bit 0 (run enable) is accepted only when the stored key bit 15 is already 1 and busy is 0. Otherwise bit 0 keeps its value.
- R3: Writes to bit 1 (time-of-day alarm IE) and bit 2 (sub-second alarm IE) are ignored while busy is 1.
- R4: An accepted write that changes any of bits 2:0 makes busy read 1 from the next bus cycle. Busy stays 1 for a full request/acknowledge round trip through two-flop synchronizers in each direction, which is at least 3 bus cycles.
- R5: When busy falls, the RTC-domain outputs `rtc_run_o`, `rtc_tod_ie_o` and `rtc_ssec_ie_o` equal bits 0, 1 and 2 of the read word.
- R6: After reset, busy falls on its own with no write, within 200 bus cycles.
- R7: Ready (bit 4) behaves as follows. `cnt_upd_i` sets it in the next cycle. `cnt_pre_i` clears it. A write of 0 clears it and a write of 1 has no effect. If an update and a clearing write arrive in the same cycle, ready ends at 1.
- R8: The alarm flags are bit 6 (time-of-day) and bit 7 (sub-second). `tod_hit_i` and `ssec_hit_i` set them. A write of 0 clears a flag and a write of 1 has no effect. A match wins over a clearing write in the same cycle.
- R9: `irq_o` is 1 exactly when at least one flag is set together with its enable: ready with ready IE (bit 5), bit 6 with bit 1, or bit 7 with bit 2. `wake_o` is 1 when either alarm flag is set.
- R10: With bit 8 set, `sqw_o` follows the source picked by bits 10:9. Code 0 selects `sq_1hz_i`, 1 selects `sq_512hz_i`, 2 selects the RTC clock divided by 8 for the 4 kHz rate, and 3 selects the RTC clock divided by 8. With bit 8 clear, `sqw_o` stays 0.
- R11: Bits 5, 8, 10:9, 14 and 15 store the written value on every write. Bits 31:16 and 13:11 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-domain clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| rtc_clk | input | 1 | RTC-domain clock |
| rtc_rst_n | input | 1 | RTC-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Current control and status word |
| cnt_pre_i | input | 1 | Pulse just before a count update (clears ready) |
| cnt_upd_i | input | 1 | Pulse on a count update (sets ready) |
| tod_hit_i | input | 1 | Time-of-day alarm match pulse |
| ssec_hit_i | input | 1 | Sub-second alarm match pulse |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Wake request from either alarm flag |
| rtc_run_o | output | 1 | RTC-domain copy of run enable |
| rtc_tod_ie_o | output | 1 | RTC-domain copy of time-of-day alarm IE |
| rtc_ssec_ie_o | output | 1 | RTC-domain copy of sub-second alarm IE |
| sq_1hz_i | input | 1 | Compensated 1 Hz source, RTC domain |
| sq_512hz_i | input | 1 | Compensated 512 Hz source, RTC domain |
| sqw_o | output | 1 | Square-wave output, RTC domain |

## Verification
Two events can update the same flag bit in the same bus cycle. A hardware set can coincide with a software clearing write of 0. The bench provokes this for ready by raising `cnt_upd_i` in the same cycle as a write of 0 to bit 4. It provokes it for the sub-second flag by raising `ssec_hit_i` in the same cycle as a write of 0 to bit 7. In both cases the flag must read 1 afterwards. Writes that land on the word while busy is high are checked separately: the guarded bits must keep their values while the unguarded fields take the new data.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;

   // bit positions that software decodes
   localparam int B_RUN   = 0;
   localparam int B_TODIE = 1;
   localparam int B_SSIE  = 2;
   localparam int B_BUSY  = 3;
   localparam int B_RDY   = 4;
   localparam int B_RDYIE = 5;
   localparam int B_TODF  = 6;
   localparam int B_SSF   = 7;
   localparam int B_SQEN  = 8;
   localparam int B_SQSEL = 9;
   localparam int B_ARD   = 14;
   localparam int B_KEY   = 15;
   localparam int MIN_W   = 16;

   typedef enum logic [1:0] {
      SQ_1HZ   = 2'd0,
      SQ_512HZ = 2'd1,
      SQ_FOURK = 2'd2,
      SQ_DIV8  = 2'd3
   } sq_sel_e;

   // fields that need a copy in the RTC domain
   typedef struct packed {
      logic ssec_ie;
      logic tod_ie;
      logic run;
   } prot_t;

   localparam int PROT_W = $bits(prot_t);

endpackage

// File: rtl/rtc_ctl_sync.sv
module rtc_ctl_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtc_ctl_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("rtc_ctl_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_ctl_bus_regs.sv
module rtc_ctl_bus_regs
   import rtc_ctl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  logic              cnt_pre,
   input  logic              cnt_upd,
   input  logic              tod_hit,
   input  logic              ssec_hit,
   output prot_t             prot_q,
   output logic              launch,
   output logic              rdy_q,
   output logic              rdy_ie_q,
   output logic              tod_f_q,
   output logic              ssec_f_q,
   output logic              sq_en_q,
   output logic [1:0]        sq_sel_q,
   output logic              ard_q,
   output logic              key_q
);
   generate
      if (DATA_W < MIN_W) begin : g_bad_width
         $error("rtc_ctl_bus_regs: DATA_W below 16");
      end
   endgenerate

   prot_t prot_nxt;
   logic  accept;

   // unused write bits
   logic unused_wr;
   assign unused_wr = ^{wr_data[DATA_W-1:MIN_W], wr_data[13:11], wr_data[B_BUSY]};

   assign accept = wr_en && !busy;

   always_comb begin
      prot_nxt = prot_q;
      if (accept) begin
         prot_nxt.tod_ie  = wr_data[B_TODIE];
         prot_nxt.ssec_ie = wr_data[B_SSIE];
         if (key_q) begin
            prot_nxt.run = wr_data[B_RUN];
         end
      end
   end

   assign launch = (prot_nxt != prot_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q   <= '0;
         rdy_ie_q <= 1'b0;
         sq_en_q  <= 1'b0;
         sq_sel_q <= 2'b00;
         ard_q    <= 1'b0;
         key_q    <= 1'b0;
      end else begin
         prot_q <= prot_nxt;
         if (wr_en) begin
            rdy_ie_q <= wr_data[B_RDYIE];
            sq_en_q  <= wr_data[B_SQEN];
            sq_sel_q <= wr_data[B_SQSEL +: 2];
            ard_q    <= wr_data[B_ARD];
            key_q    <= wr_data[B_KEY];
         end
      end
   end

   // hardware set wins over software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q    <= 1'b0;
         tod_f_q  <= 1'b0;
         ssec_f_q <= 1'b0;
      end else begin
         if (cnt_upd) begin
            rdy_q <= 1'b1;
         end else if (cnt_pre || (wr_en && !wr_data[B_RDY])) begin
            rdy_q <= 1'b0;
         end

         if (tod_hit) begin
            tod_f_q <= 1'b1;
         end else if (wr_en && !wr_data[B_TODF]) begin
            tod_f_q <= 1'b0;
         end

         if (ssec_hit) begin
            ssec_f_q <= 1'b1;
         end else if (wr_en && !wr_data[B_SSF]) begin
            ssec_f_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rtc_ctl_xfer.sv
module rtc_ctl_xfer #(
   parameter int W           = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic         bus_clk,
   input  logic         bus_rst_n,
   input  logic         launch,
   input  logic [W-1:0] bus_val,
   output logic         busy,
   input  logic         rtc_clk,
   input  logic         rtc_rst_n,
   output logic [W-1:0] rtc_val
);
   logic req_q;
   logic ack_s;
   logic req_s;
   logic seen_q;

   // request starts at 1 so that reset itself opens one round trip
   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         req_q <= 1'b1;
      end else if (launch) begin
         req_q <= ~req_q;
      end
   end

   rtc_ctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (rtc_clk),
      .rst_n (rtc_rst_n),
      .d     (req_q),
      .q     (req_s)
   );

   always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) begin
         seen_q  <= 1'b0;
         rtc_val <= '0;
      end else if (req_s != seen_q) begin
         seen_q  <= req_s;
         rtc_val <= bus_val;
      end
   end

   rtc_ctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (bus_clk),
      .rst_n (bus_rst_n),
      .d     (seen_q),
      .q     (ack_s)
   );

   assign busy = req_q ^ ack_s;
endmodule

// File: rtl/rtc_ctl_sqw.sv
module rtc_ctl_sqw
   import rtc_ctl_pkg::*;
#(
   parameter int FOURK_LOG2  = 3,
   parameter int RAW_LOG2    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       rtc_clk,
   input  logic       rtc_rst_n,
   input  logic       sq_en_bus,
   input  logic [1:0] sq_sel_bus,
   input  logic       src_1hz,
   input  logic       src_512hz,
   output logic       sqw_o
);
   localparam int DIV_W = (FOURK_LOG2 > RAW_LOG2) ? FOURK_LOG2 : RAW_LOG2;

   generate
      if (FOURK_LOG2 < 1 || RAW_LOG2 < 1) begin : g_bad_div
         $error("rtc_ctl_sqw: divider taps must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             tap_fourk;
   logic             tap_raw;
   logic [2:0]       cfg_s;
   logic             en_s;
   sq_sel_e          sel_s;
   logic             pick;

   always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   generate
      if (FOURK_LOG2 == RAW_LOG2) begin : g_shared_tap
         assign tap_fourk = div_q[FOURK_LOG2-1];
         assign tap_raw   = tap_fourk;
      end else begin : g_split_tap
         assign tap_fourk = div_q[FOURK_LOG2-1];
         assign tap_raw   = div_q[RAW_LOG2-1];
      end
   endgenerate

   rtc_ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_cfg_sync (
      .clk   (rtc_clk),
      .rst_n (rtc_rst_n),
      .d     ({sq_en_bus, sq_sel_bus}),
      .q     (cfg_s)
   );

   assign en_s  = cfg_s[2];
   assign sel_s = sq_sel_e'(cfg_s[1:0]);

   always_comb begin
      unique case (sel_s)
         SQ_1HZ:   pick = src_1hz;
         SQ_512HZ: pick = src_512hz;
         SQ_FOURK: pick = tap_fourk;
         default:  pick = tap_raw;
      endcase
   end

   always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) begin
         sqw_o <= 1'b0;
      end else begin
         sqw_o <= en_s & pick;
      end
   end
endmodule

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
   import rtc_ctl_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FOURK_LOG2  = 3,
   parameter int RAW_LOG2    = 3
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              rtc_clk,
   input  logic              rtc_rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              cnt_pre_i,
   input  logic              cnt_upd_i,
   input  logic              tod_hit_i,
   input  logic              ssec_hit_i,
   output logic              irq_o,
   output logic              wake_o,
   output logic              rtc_run_o,
   output logic              rtc_tod_ie_o,
   output logic              rtc_ssec_ie_o,
   input  logic              sq_1hz_i,
   input  logic              sq_512hz_i,
   output logic              sqw_o
);
   prot_t             prot_q;
   logic              launch;
   logic              busy;
   logic              rdy_q;
   logic              rdy_ie_q;
   logic              tod_f_q;
   logic              ssec_f_q;
   logic              sq_en_q;
   logic [1:0]        sq_sel_q;
   logic              ard_q;
   logic              key_q;
   logic [PROT_W-1:0] rtc_prot;
   prot_t             rtc_copy;

   rtc_ctl_bus_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (bus_clk),
      .rst_n    (bus_rst_n),
      .wr_en    (wr_en_i),
      .wr_data  (wr_data_i),
      .busy     (busy),
      .cnt_pre  (cnt_pre_i),
      .cnt_upd  (cnt_upd_i),
      .tod_hit  (tod_hit_i),
      .ssec_hit (ssec_hit_i),
      .prot_q   (prot_q),
      .launch   (launch),
      .rdy_q    (rdy_q),
      .rdy_ie_q (rdy_ie_q),
      .tod_f_q  (tod_f_q),
      .ssec_f_q (ssec_f_q),
      .sq_en_q  (sq_en_q),
      .sq_sel_q (sq_sel_q),
      .ard_q    (ard_q),
      .key_q    (key_q)
   );

   rtc_ctl_xfer #(.W(PROT_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
      .bus_clk   (bus_clk),
      .bus_rst_n (bus_rst_n),
      .launch    (launch),
      .bus_val   (prot_q),
      .busy      (busy),
      .rtc_clk   (rtc_clk),
      .rtc_rst_n (rtc_rst_n),
      .rtc_val   (rtc_prot)
   );

   assign rtc_copy      = prot_t'(rtc_prot);
   assign rtc_run_o     = rtc_copy.run;
   assign rtc_tod_ie_o  = rtc_copy.tod_ie;
   assign rtc_ssec_ie_o = rtc_copy.ssec_ie;

   rtc_ctl_sqw #(
      .FOURK_LOG2  (FOURK_LOG2),
      .RAW_LOG2    (RAW_LOG2),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sqw (
      .rtc_clk    (rtc_clk),
      .rtc_rst_n  (rtc_rst_n),
      .sq_en_bus  (sq_en_q),
      .sq_sel_bus (sq_sel_q),
      .src_1hz    (sq_1hz_i),
      .src_512hz  (sq_512hz_i),
      .sqw_o      (sqw_o)
   );

   always_comb begin
      rd_data_o                   = '0;
      rd_data_o[B_RUN]            = prot_q.run;
      rd_data_o[B_TODIE]          = prot_q.tod_ie;
      rd_data_o[B_SSIE]           = prot_q.ssec_ie;
      rd_data_o[B_BUSY]           = busy;
      rd_data_o[B_RDY]            = rdy_q;
      rd_data_o[B_RDYIE]          = rdy_ie_q;
      rd_data_o[B_TODF]           = tod_f_q;
      rd_data_o[B_SSF]            = ssec_f_q;
      rd_data_o[B_SQEN]           = sq_en_q;
      rd_data_o[B_SQSEL +: 2]     = sq_sel_q;
      rd_data_o[B_ARD]            = ard_q;
      rd_data_o[B_KEY]            = key_q;
   end

   assign irq_o  = (rdy_q & rdy_ie_q) | (tod_f_q & prot_q.tod_ie) | (ssec_f_q & prot_q.ssec_ie);
   assign wake_o = tod_f_q | ssec_f_q;
endmodule

// File: rtl/rtc_ctl_reg_chk.sv
module rtc_ctl_reg_chk (
   input logic bus_clk,
   input logic bus_rst_n,
   input logic wr_en,
   input logic cnt_upd,
   input logic tod_hit,
   input logic run_q,
   input logic tod_ie_q,
   input logic ssec_ie_q,
   input logic busy_q,
   input logic key_q,
   input logic rdy_q,
   input logic tod_f_q,
   input logic rtc_run,
   input logic rtc_tod_ie,
   input logic rtc_ssec_ie
);
   // R2
   run_guard_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (wr_en && (busy_q || !key_q)) |=> $stable(run_q));

   // R2
   run_idle_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      !wr_en |=> $stable(run_q));

   // R3
   ie_guard_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (wr_en && busy_q) |=> ($stable(tod_ie_q) && $stable(ssec_ie_q)));

   // R4
   busy_rise_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $rose(busy_q) |-> $past(wr_en));

   // R5
   busy_fall_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $fell(busy_q) |-> (rtc_run == run_q && rtc_tod_ie == tod_ie_q && rtc_ssec_ie == ssec_ie_q));

   // R7
   rdy_set_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      cnt_upd |=> rdy_q);

   // R8
   tod_set_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      tod_hit |=> tod_f_q);
endmodule

bind rtc_ctl_reg rtc_ctl_reg_chk u_chk (
   .bus_clk     (bus_clk),
   .bus_rst_n   (bus_rst_n),
   .wr_en       (wr_en_i),
   .cnt_upd     (cnt_upd_i),
   .tod_hit     (tod_hit_i),
   .run_q       (rd_data_o[0]),
   .tod_ie_q    (rd_data_o[1]),
   .ssec_ie_q   (rd_data_o[2]),
   .busy_q      (rd_data_o[3]),
   .key_q       (rd_data_o[15]),
   .rdy_q       (rd_data_o[4]),
   .tod_f_q     (rd_data_o[6]),
   .rtc_run     (rtc_run_o),
   .rtc_tod_ie  (rtc_tod_ie_o),
   .rtc_ssec_ie (rtc_ssec_ie_o)
);

// File: tb/tb_rtc_ctl_reg.sv
`timescale 1ns/1ps
module tb_rtc_ctl_reg;
   logic        bus_clk = 1'b0;
   logic        rtc_clk = 1'b0;
   logic        bus_rst_n = 1'b0;
   logic        rtc_rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        cnt_pre = 1'b0;
   logic        cnt_upd = 1'b0;
   logic        tod_hit = 1'b0;
   logic        ssec_hit = 1'b0;
   logic        irq, wake, rtc_run, rtc_tod_ie, rtc_ssec_ie;
   logic        sq_1hz = 1'b0;
   logic        sq_512hz = 1'b0;
   logic        sqw;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2.5 bus_clk = ~bus_clk;
   always #15  rtc_clk = ~rtc_clk;

   rtc_ctl_reg dut (
      .bus_clk       (bus_clk),
      .bus_rst_n     (bus_rst_n),
      .rtc_clk       (rtc_clk),
      .rtc_rst_n     (rtc_rst_n),
      .wr_en_i       (wr_en),
      .wr_data_i     (wr_data),
      .rd_data_o     (rd_data),
      .cnt_pre_i     (cnt_pre),
      .cnt_upd_i     (cnt_upd),
      .tod_hit_i     (tod_hit),
      .ssec_hit_i    (ssec_hit),
      .irq_o         (irq),
      .wake_o        (wake),
      .rtc_run_o     (rtc_run),
      .rtc_tod_ie_o  (rtc_tod_ie),
      .rtc_ssec_ie_o (rtc_ssec_ie),
      .sq_1hz_i      (sq_1hz),
      .sq_512hz_i    (sq_512hz),
      .sqw_o         (sqw)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle of stimulus, returns at the following falling edge
   task automatic drive(input bit upd, input bit pre, input bit th, input bit sh,
                        input bit wr, input logic [31:0] d);
      @(negedge bus_clk);
      cnt_upd = upd; cnt_pre = pre; tod_hit = th; ssec_hit = sh;
      wr_en = wr; wr_data = d;
      @(negedge bus_clk);
      cnt_upd = 0; cnt_pre = 0; tod_hit = 0; ssec_hit = 0; wr_en = 0;
   endtask

   task automatic bus_wr(input logic [31:0] d);
      drive(0, 0, 0, 0, 1, d);
   endtask

   task automatic wait_idle(output int cycles);
      cycles = 0;
      while (rd_data[3] && cycles < 200) begin
         @(negedge bus_clk);
         cycles++;
      end
   endtask

   task automatic count_rises(input int n, output int rises);
      logic prev;
      rises = 0;
      @(negedge rtc_clk);
      prev = sqw;
      for (int i = 0; i < n; i++) begin
         @(negedge rtc_clk);
         if (sqw && !prev) rises++;
         prev = sqw;
      end
   endtask

   task automatic t_reset();
      int c;
      chk("R1 reset word", rd_data, 32'h0000_0008);
      chk("R1 irq/wake/sqw", {29'd0, irq, wake, sqw}, 32'd0);
      wait_idle(c);
      chk("R6 busy self-clears", {31'd0, (c < 200)}, 32'd1);
      chk("R6 word after idle", rd_data, 32'h0);
   endtask

   task automatic t_plain_and_guard();
      // key stored 0: run write ignored, no busy
      bus_wr(32'h0000_0001);
      chk("R2 run ignored without key", rd_data, 32'h0);
      bus_wr(32'hFFFF_FF20);
      chk("R11 plain fields and zero bits", rd_data, 32'h0000_C720);
   endtask

   task automatic t_handshake();
      int c;
      bus_wr(32'h0000_8001);
      chk("R2 R4 run accepted, busy set", rd_data, 32'h0000_8009);
      // written while busy: guarded bits keep old value
      bus_wr(32'h0000_8006);
      chk("R3 R2 guarded bits held while busy", rd_data, 32'h0000_8009);
      wait_idle(c);
      chk("R4 busy lasts a round trip", {31'd0, (c >= 2 && c < 200)}, 32'd1);
      chk("R5 rtc copy after run set", {29'd0, rtc_ssec_ie, rtc_tod_ie, rtc_run}, 32'd1);
      chk("R5 word after idle", rd_data, 32'h0000_8001);
      bus_wr(32'h0000_8006);
      chk("R3 ie accepted when idle", rd_data, 32'h0000_800E);
      wait_idle(c);
      chk("R5 rtc copy after ie set", {29'd0, rtc_ssec_ie, rtc_tod_ie, rtc_run}, 32'd6);
   endtask

   task automatic t_ready();
      drive(1, 0, 0, 0, 0, 0);
      chk("R7 update sets ready", rd_data, 32'h0000_8016);
      bus_wr(32'h0000_8016);
      chk("R7 write 1 keeps ready", rd_data, 32'h0000_8016);
      drive(0, 1, 0, 0, 0, 0);
      chk("R7 pre-update clears ready", rd_data, 32'h0000_8006);
      drive(1, 0, 0, 0, 0, 0);
      bus_wr(32'h0000_8006);
      chk("R7 write 0 clears ready", rd_data, 32'h0000_8006);
      drive(1, 0, 0, 0, 1, 32'h0000_8006);
      chk("R7 update wins over clear", rd_data, 32'h0000_8016);
      bus_wr(32'h0000_8006);
   endtask

   task automatic t_alarm();
      int c;
      drive(0, 0, 1, 0, 0, 0);
      chk("R8 tod hit sets flag", rd_data, 32'h0000_8046);
      chk("R9 irq and wake on tod", {30'd0, irq, wake}, 32'd3);
      bus_wr(32'h0000_8006);
      chk("R8 write 0 clears tod", rd_data, 32'h0000_8006);
      chk("R9 irq and wake low", {30'd0, irq, wake}, 32'd0);
      drive(0, 0, 0, 1, 1, 32'h0000_8006);
      chk("R8 ssec hit wins over clear", rd_data, 32'h0000_8086);
      bus_wr(32'h0000_80C6);
      chk("R8 write 1 does not set flag", rd_data, 32'h0000_8086);
      chk("R9 irq from ssec", {31'd0, irq}, 32'd1);
      bus_wr(32'h0000_8080);
      wait_idle(c);
      chk("R9 ie cleared, flag kept", rd_data, 32'h0000_8080);
      chk("R9 irq masked, wake set", {30'd0, irq, wake}, 32'd1);
      drive(1, 0, 0, 0, 0, 0);
      chk("R9 ready without ie no irq", {31'd0, irq}, 32'd0);
      bus_wr(32'h0000_80B0);
      chk("R9 ready with ie", {rd_data[15:0], 15'd0, irq}, {16'h80B0, 16'd1});
      bus_wr(32'h0000_8000);
      chk("R9 all cleared", {rd_data[29:0], irq, wake}, {30'h0000_8000, 2'b00});
   endtask

   task automatic t_sqw();
      int r;
      bus_wr(32'h0000_8100);
      sq_1hz = 1; sq_512hz = 0;
      repeat (6) @(negedge rtc_clk);
      chk("R10 sel 0 follows 1 Hz high", {31'd0, sqw}, 32'd1);
      sq_1hz = 0;
      repeat (3) @(negedge rtc_clk);
      chk("R10 sel 0 follows 1 Hz low", {31'd0, sqw}, 32'd0);
      bus_wr(32'h0000_8300);
      sq_1hz = 1; sq_512hz = 1;
      repeat (6) @(negedge rtc_clk);
      chk("R10 sel 1 follows 512 Hz high", {31'd0, sqw}, 32'd1);
      sq_512hz = 0;
      repeat (3) @(negedge rtc_clk);
      chk("R10 sel 1 ignores 1 Hz", {31'd0, sqw}, 32'd0);
      bus_wr(32'h0000_8500);
      repeat (6) @(negedge rtc_clk);
      count_rises(80, r);
      chk("R10 sel 2 divide by 8", {31'd0, (r >= 9 && r <= 11)}, 32'd1);
      bus_wr(32'h0000_8700);
      repeat (6) @(negedge rtc_clk);
      count_rises(80, r);
      chk("R10 sel 3 divide by 8", {31'd0, (r >= 9 && r <= 11)}, 32'd1);
      bus_wr(32'h0000_8600);
      repeat (6) @(negedge rtc_clk);
      count_rises(40, r);
      chk("R10 disabled output quiet", {31'd0, sqw} | r, 32'd0);
   endtask

   initial begin : wdog
      repeat (200000) @(posedge bus_clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge rtc_clk);
      @(negedge bus_clk);
      t_reset_pre();
      bus_rst_n = 1;
      rtc_rst_n = 1;
      t_reset();
      t_plain_and_guard();
      t_handshake();
      t_ready();
      t_alarm();
      t_sqw();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   task automatic t_reset_pre();
      chk("R1 word during reset", rd_data, 32'h0000_0008);
   endtask
endmodule